// File: doc/BRIEF.md
# Quadrature Position Counter with Debounced Inputs

This block keeps a 32-bit signed position count driven by two encoder lines, A and B, plus a third marker line, Z. Each line first passes through a two-flop synchroniser and a debounce filter. The filter passes a new level only after that level has held for a programmable number of clocks.

The filtered A/B pair is then decoded in one of four ways, chosen by `cfg_mode`:

- as a Gray-coded quadrature pair;
- as a 2-bit binary count;
- as a count strobe on A, with the direction given by the level of B;
- as two independent strobes, where A counts up and B counts down.

Two compare values, one upper and one lower, flag the moment the count steps past them. They can optionally fold the count back to zero at that moment. The Z line either clears the count while it is active, or serves only as a debounced push-button level.

Every accepted step produces a one-cycle event pulse and a direction bit. An interval timer outside this block can use these to measure the spacing of counts.

Top module: `qdc_counter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `count` is 0 and `cnt_evt`, `cnt_up`, `irq_hi`, `irq_lo`, `err_flag` and `btn_level` are 0.
- R2: With `cfg_mode`=0 (quadrature), the code {A,B} (A is bit 1) stepping 00→10→11→01→00 adds one per transition, and the reverse order subtracts one.
- R3: With `cfg_mode`=1 (binary), {A,B} is read as an unsigned 2-bit value (A is the MSB). A change of +1 modulo 4 counts up and a change of −1 modulo 4 counts down.
- R4: In modes 0 and 1, a code change of two positions leaves `count` unchanged and sets `err_flag`. `err_flag` then stays set until a cycle with `err_clr` high and no new illegal change.
- R5: With `cfg_mode`=2, each rising edge of filtered A counts once: up when filtered B is 1, down when it is 0. Changes of B alone never count.
- R6: With `cfg_mode`=3, a rising edge of A counts up and a rising edge of B counts down. Both edges in the same cycle give no count.
- R7: A pin level reaches the decoder only after it has been sampled unchanged for 2^`cfg_filt` consecutive clocks. Shorter pulses are ignored. A clean edge on a pin changes `count` on the (3 + 2^`cfg_filt`)-th rising clock edge after it.
- R8: When `cfg_zm_en` is 1 and filtered Z is 1, `count` becomes 0 on the next edge, and this overrides any step. When `cfg_zm_en` is 0, Z has no effect on `count`. `btn_level` always shows filtered Z.
- R9: An up step taken from `count` == `bound_hi` pulses `irq_hi` for one cycle, and a down step from `count` == `bound_lo` pulses `irq_lo`. The new count is 0 when `cfg_autozero` is 1, and ±1 otherwise.
- R10: `cnt_evt` is high for exactly the cycle in which a step is applied to `count`, with `cnt_up` giving that step's direction. A zero-marker clear raises no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 quadrature, 1 binary, 2 direction-level, 3 up/down edges |
| cfg_filt | input | 4 | Debounce exponent N; stability time is 2^N clocks |
| cfg_zm_en | input | 1 | Lets an active Z clear the count |
| cfg_autozero | input | 1 | Crossing a bound reloads zero |
| err_clr | input | 1 | Clears the illegal-transition flag |
| bound_hi | input | 32 | Upper compare value |
| bound_lo | input | 32 | Lower compare value |
| in_a | input | 1 | Encoder line A |
| in_b | input | 1 | Encoder line B |
| in_z | input | 1 | Zero marker or push-button line |
| count | output | 32 | Position count |
| cnt_evt | output | 1 | One-cycle pulse per applied step |
| cnt_up | output | 1 | Direction of the latest step |
| irq_hi | output | 1 | Upper bound crossed |
| irq_lo | output | 1 | Lower bound crossed |
| err_flag | output | 1 | Sticky illegal-transition flag |
| btn_level | output | 1 | Debounced Z level |

## Verification
The same A/B pins are driven through every mode. Full forward and reverse Gray cycles separate up decoding from down decoding. Binary sequences that wrap through 11→00 show that the binary path is not the Gray path. Two-position jumps show that a fault is flagged rather than counted.

The direction-level and edge modes are driven with B toggling alone and with simultaneous A/B rises. This exposes decoders that react to the wrong line or that fail to cancel a double edge. Bound crossings are run in both fold and pass-through settings. A sub-threshold glitch followed by a timed clean edge pins down both the rejection and the exact latency of the filter.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

  typedef enum logic [1:0] {
    MODE_QUAD   = 2'd0,
    MODE_BIN    = 2'd1,
    MODE_DIRLVL = 2'd2,
    MODE_EDGES  = 2'd3
  } qdc_mode_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic bad;
  } qdc_step_t;

endpackage

// File: rtl/qdc_debounce.sv
module qdc_debounce #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             pin,
  output logic             level
);
  localparam int RUN_W = (1 << SEL_W) - 1;

  logic             sync1, sync2;
  logic [RUN_W-1:0] run;
  logic [RUN_W-1:0] lim;

  assign lim = RUN_W'((32'd1 << sel) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      level <= 1'b0;
      run   <= '0;
    end else begin
      sync1 <= pin;
      sync2 <= sync1;
      if (sync2 != level) begin
        if (run == lim) begin
          level <= sync2;
          run   <= '0;
        end else begin
          run <= run + RUN_W'(1);
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/qdc_decode.sv
module qdc_decode
  import qdc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  qdc_mode_e mode,
  input  logic      a,
  input  logic      b,
  output qdc_step_t step
);
  logic       pa, pb;
  logic [1:0] d_gray, d_bin, delta;
  logic       rise_a, rise_b;

  function automatic logic [1:0] gray_pos(input logic [1:0] c);
    case (c)
      2'b00:   gray_pos = 2'd0;
      2'b10:   gray_pos = 2'd1;
      2'b11:   gray_pos = 2'd2;
      default: gray_pos = 2'd3;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pa <= 1'b0;
      pb <= 1'b0;
    end else begin
      pa <= a;
      pb <= b;
    end
  end

  assign d_gray = gray_pos({a, b}) - gray_pos({pa, pb});
  assign d_bin  = {a, b} - {pa, pb};
  assign delta  = (mode == MODE_QUAD) ? d_gray : d_bin;
  assign rise_a = a & ~pa;
  assign rise_b = b & ~pb;

  always_comb begin
    step = '0;
    case (mode)
      MODE_QUAD, MODE_BIN: begin
        step.up  = (delta == 2'd1);
        step.dn  = (delta == 2'd3);
        step.bad = (delta == 2'd2);
      end
      MODE_DIRLVL: begin
        step.up = rise_a & b;
        step.dn = rise_a & ~b;
      end
      default: begin
        step.up = rise_a & ~rise_b;
        step.dn = rise_b & ~rise_a;
      end
    endcase
  end
endmodule

// File: rtl/qdc_core.sv
module qdc_core
  import qdc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  qdc_step_t        step,
  input  logic             zclr,
  input  logic             autozero,
  input  logic             err_clr,
  input  logic [CNT_W-1:0] hi,
  input  logic [CNT_W-1:0] lo,
  output logic [CNT_W-1:0] count,
  output logic             evt,
  output logic             dir_up,
  output logic             irq_hi,
  output logic             irq_lo,
  output logic             err
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      evt    <= 1'b0;
      dir_up <= 1'b0;
      irq_hi <= 1'b0;
      irq_lo <= 1'b0;
      err    <= 1'b0;
    end else begin
      evt    <= 1'b0;
      irq_hi <= 1'b0;
      irq_lo <= 1'b0;
      if (zclr) begin
        count <= '0;
      end else if (step.up) begin
        evt    <= 1'b1;
        dir_up <= 1'b1;
        if (count == hi) begin
          irq_hi <= 1'b1;
          count  <= autozero ? '0 : count + ONE;
        end else begin
          count <= count + ONE;
        end
      end else if (step.dn) begin
        evt    <= 1'b1;
        dir_up <= 1'b0;
        if (count == lo) begin
          irq_lo <= 1'b1;
          count  <= autozero ? '0 : count - ONE;
        end else begin
          count <= count - ONE;
        end
      end
      if (step.bad)    err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end
endmodule

// File: rtl/qdc_counter.sv
module qdc_counter
  import qdc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic [FILT_W-1:0] cfg_filt,
  input  logic              cfg_zm_en,
  input  logic              cfg_autozero,
  input  logic              err_clr,
  input  logic [CNT_W-1:0]  bound_hi,
  input  logic [CNT_W-1:0]  bound_lo,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              in_z,
  output logic [CNT_W-1:0]  count,
  output logic              cnt_evt,
  output logic              cnt_up,
  output logic              irq_hi,
  output logic              irq_lo,
  output logic              err_flag,
  output logic              btn_level
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] raw, flt;
  qdc_step_t       step;

  assign raw = {in_z, in_b, in_a};

  for (genvar gi = 0; gi < NPIN; gi++) begin : g_flt
    qdc_debounce #(.SEL_W(FILT_W)) u_db (
      .clk  (clk),
      .rst  (rst),
      .sel  (cfg_filt),
      .pin  (raw[gi]),
      .level(flt[gi])
    );
  end

  qdc_decode u_dec (
    .clk (clk),
    .rst (rst),
    .mode(qdc_mode_e'(cfg_mode)),
    .a   (flt[0]),
    .b   (flt[1]),
    .step(step)
  );

  qdc_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .zclr    (cfg_zm_en & flt[2]),
    .autozero(cfg_autozero),
    .err_clr (err_clr),
    .hi      (bound_hi),
    .lo      (bound_lo),
    .count   (count),
    .evt     (cnt_evt),
    .dir_up  (cnt_up),
    .irq_hi  (irq_hi),
    .irq_lo  (irq_lo),
    .err     (err_flag)
  );

  assign btn_level = flt[2];
endmodule

// File: rtl/qdc_chk.sv
module qdc_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_autozero,
  input logic             err_clr,
  input logic [CNT_W-1:0] count,
  input logic             cnt_evt,
  input logic             cnt_up,
  input logic             irq_hi,
  input logic             irq_lo,
  input logic             err_flag
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R10
  evt_up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_evt && !cfg_autozero && cnt_up) |-> (count == $past(count) + ONE));

  // R10
  evt_dn_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_evt && !cfg_autozero && !cnt_up) |-> (count == $past(count) - ONE));

  // R8
  quiet_count_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_evt |-> (count == $past(count) || count == '0));

  // R9
  irq_hi_dir_chk: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> (cnt_evt && cnt_up));

  // R9
  irq_lo_dir_chk: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> (cnt_evt && !cnt_up));

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_hi, irq_lo}));

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);
endmodule

bind qdc_counter qdc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_autozero(cfg_autozero),
  .err_clr     (err_clr),
  .count       (count),
  .cnt_evt     (cnt_evt),
  .cnt_up      (cnt_up),
  .irq_hi      (irq_hi),
  .irq_lo      (irq_lo),
  .err_flag    (err_flag)
);

// File: tb/sim_qdc_counter.sv
module sim_qdc_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'd0;
  logic [3:0]  cfg_filt = 4'd0;
  logic        cfg_zm_en = 1'b0;
  logic        cfg_autozero = 1'b0;
  logic        err_clr = 1'b0;
  logic [31:0] bound_hi = 32'h7FFF_FFFF;
  logic [31:0] bound_lo = 32'h8000_0000;
  logic        in_a = 1'b0, in_b = 1'b0, in_z = 1'b0;
  logic [31:0] count;
  logic        cnt_evt, cnt_up, irq_hi, irq_lo, err_flag, btn_level;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  qdc_counter u0 (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_filt(cfg_filt),
    .cfg_zm_en(cfg_zm_en), .cfg_autozero(cfg_autozero), .err_clr(err_clr),
    .bound_hi(bound_hi), .bound_lo(bound_lo),
    .in_a(in_a), .in_b(in_b), .in_z(in_z),
    .count(count), .cnt_evt(cnt_evt), .cnt_up(cnt_up), .irq_hi(irq_hi),
    .irq_lo(irq_lo), .err_flag(err_flag), .btn_level(btn_level)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_cnt;
  bit m_evt, m_up, m_ih, m_il, m_err;
  bit pipe [3][$];     // per-pin sampled history (two-stage delay)
  bit m_lvl [3];       // accepted levels
  bit m_old [3];       // accepted levels one cycle ago
  int m_run [3];
  int qpos [4] = '{0, 3, 1, 2};

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_evt = 0; m_up = 0; m_ih = 0; m_il = 0; m_err = 0;
      for (int i = 0; i < 3; i++) begin
        pipe[i] = '{0, 0}; m_lvl[i] = 0; m_old[i] = 0; m_run[i] = 0;
      end
    end else begin
      int nv, ov, d;
      bit su, sd, sb, ra, rb;
      nv = 2 * m_lvl[0] + m_lvl[1];
      ov = 2 * m_old[0] + m_old[1];
      ra = m_lvl[0] && !m_old[0];
      rb = m_lvl[1] && !m_old[1];
      su = 0; sd = 0; sb = 0;
      case (cfg_mode)
        2'd0, 2'd1: begin
          if (cfg_mode == 2'd0) d = (qpos[nv] - qpos[ov] + 4) % 4;
          else                  d = (nv - ov + 4) % 4;
          su = (d == 1); sd = (d == 3); sb = (d == 2);
        end
        2'd2: begin su = ra && m_lvl[1]; sd = ra && !m_lvl[1]; end
        default: begin su = ra && !rb; sd = rb && !ra; end
      endcase
      m_evt = 0; m_ih = 0; m_il = 0;
      if (cfg_zm_en && m_lvl[2]) m_cnt = 0;
      else if (su || sd) begin
        m_evt = 1; m_up = su;
        if (su && m_cnt == bound_hi) begin
          m_ih = 1; m_cnt = cfg_autozero ? 0 : m_cnt + 1;
        end else if (sd && m_cnt == bound_lo) begin
          m_il = 1; m_cnt = cfg_autozero ? 0 : m_cnt - 1;
        end else m_cnt = su ? m_cnt + 1 : m_cnt - 1;
      end
      if (sb) m_err = 1; else if (err_clr) m_err = 0;
      for (int i = 0; i < 3; i++) begin
        m_old[i] = m_lvl[i];
        if (pipe[i][0] != m_lvl[i]) begin
          m_run[i]++;
          if (m_run[i] >= (1 << cfg_filt)) begin
            m_lvl[i] = pipe[i][0]; m_run[i] = 0;
          end
        end else m_run[i] = 0;
      end
      pipe[0].push_back(in_a); pipe[1].push_back(in_b); pipe[2].push_back(in_z);
      for (int i = 0; i < 3; i++) void'(pipe[i].pop_front());
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2/R3 count",  count,            m_cnt);
      chk("R10 evt",      32'(cnt_evt),     32'(m_evt));
      chk("R10 dir",      32'(cnt_up),      32'(m_up));
      chk("R9 irq_hi",    32'(irq_hi),      32'(m_ih));
      chk("R9 irq_lo",    32'(irq_lo),      32'(m_il));
      chk("R4 err",       32'(err_flag),    32'(m_err));
      chk("R8 btn",       32'(btn_level),   32'(m_lvl[2]));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int settle();
    return (1 << cfg_filt) + 5;
  endfunction

  task automatic ab(bit a, bit b);
    in_a = a; in_b = b; tick(settle());
  endtask

  task automatic pulse_a();
    in_a = 1; tick(settle()); in_a = 0; tick(settle());
  endtask

  task automatic pulse_b();
    in_b = 1; tick(settle()); in_b = 0; tick(settle());
  endtask

  task automatic clr_err();
    err_clr = 1; tick(1); err_clr = 0; tick(1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] base;
    tick(3);
    // R1 reset state
    chk("R1 count in reset", count, 32'd0);
    chk("R1 flags in reset", {26'd0, cnt_evt, cnt_up, irq_hi, irq_lo, err_flag, btn_level}, 32'd0);
    rst = 0;
    tick(1);
    chk("R1 count after reset", count, 32'd0);

    // R2 quadrature
    for (int k = 0; k < 2; k++) begin ab(1,0); ab(1,1); ab(0,1); ab(0,0); end
    chk("R2 eight up", count, 32'd8);
    ab(0,1); ab(1,1); ab(1,0);
    chk("R2 three down", count, 32'd5);
    // R4 illegal quadrature jump 10 -> 01
    ab(0,1);
    chk("R4 quad jump no count", count, 32'd5);
    chk("R4 quad jump flag", 32'(err_flag), 32'd1);
    tick(4);
    chk("R4 flag sticky", 32'(err_flag), 32'd1);
    clr_err();
    chk("R4 flag cleared", 32'(err_flag), 32'd0);

    // R3 binary from value 1
    cfg_mode = 2'd1; tick(2);
    ab(1,0); ab(1,1); ab(0,0); ab(0,1);
    chk("R3 binary up wrap", count, 32'd9);
    ab(0,0); ab(1,1);
    chk("R3 binary down wrap", count, 32'd7);
    ab(0,1);
    chk("R4 binary jump no count", count, 32'd7);
    chk("R4 binary jump flag", 32'(err_flag), 32'd1);
    clr_err();

    // R8 zero marker
    cfg_mode = 2'd2; tick(2);
    in_z = 1; tick(settle());
    chk("R8 disabled marker ignored", count, 32'd7);
    chk("R8 button level", 32'(btn_level), 32'd1);
    cfg_zm_en = 1; tick(2);
    chk("R8 marker clears", count, 32'd0);
    in_z = 0; tick(settle());

    // R5 direction level
    for (int k = 0; k < 3; k++) pulse_a();
    in_b = 0; tick(settle());
    for (int k = 0; k < 2; k++) pulse_a();
    chk("R5 level direction", count, 32'd1);

    // R6 edge pair
    cfg_mode = 2'd3; tick(2);
    pulse_a(); pulse_a(); pulse_b();
    chk("R6 edge up/down", count, 32'd2);
    in_a = 1; in_b = 1; tick(settle()); in_a = 0; in_b = 0; tick(settle());
    chk("R6 double edge cancels", count, 32'd2);

    // R9 bounds, pass-through
    bound_hi = 32'd3; bound_lo = 32'hFFFF_FFFE; tick(1);
    pulse_a(); pulse_a();
    chk("R9 pass past upper", count, 32'd4);
    in_z = 1; tick(settle()); in_z = 0; tick(settle());
    cfg_autozero = 1;
    for (int k = 0; k < 4; k++) pulse_a();
    chk("R9 autozero upper", count, 32'd0);
    pulse_b(); pulse_b();
    chk("R9 reach lower", count, 32'hFFFF_FFFE);
    pulse_b();
    chk("R9 autozero lower", count, 32'd0);

    // R7 debounce
    cfg_filt = 4'd3; tick(2);
    base = count;
    in_a = 1; tick(5); in_a = 0; tick(20);
    chk("R7 glitch ignored", count, base);
    in_a = 1; tick(10);
    chk("R7 not yet", count, base);
    tick(1);
    chk("R7 exact latency", count, base + 32'd1);
    in_a = 0; tick(20);
    tick(4);
    summary();
  end
endmodule